// File: doc/BRIEF.md
# Configuration-Port I2C Target with Broadcast Reset

This block is the serial front end of a configuration device on a shared two-wire bus. It runs entirely on the system clock. The raw SCL and SDA lines are oversampled, synchronised and majority-filtered. Bus conditions and clock edges are then extracted from the clean copies, and a byte-level state machine handles addressing, acknowledgement, write delivery and read transmission.

Write bytes addressed to the device appear on a parallel byte port with a one-cycle strobe. Read bytes are captured from a parallel input at the start of each transmitted byte. The block also watches for a broadcast address followed by a reset code and turns that into a one-cycle soft-reset pulse. It recognises the high-speed controller code, leaves that code unacknowledged, and raises a mode flag that lasts until the bus is released.

The block never drives SCL. On SDA it provides only a pull-down enable for an open-drain pad.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The device answers the 7-bit address formed by 6'b111010 followed by `addr_sel_i` (74h with select low, 75h with select high). Address bits are taken on SCL rising edges, MSB first, and the eighth bit is R/W (1 = read). A matching address byte is acknowledged by holding SDA low through the ninth SCL clock.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one releases SDA. A repeated START restarts the address phase.
- R3: In a write to the device, every data byte is received MSB first, presented on `wr_data_o` with a one-cycle `wr_valid_o` pulse, and acknowledged.
- R4: When an address byte does not match, nothing is acknowledged, no `wr_valid_o` is produced, and SDA stays released until the next START or STOP.
- R5: After a matching read address, the device captures `rd_data_i` when the acknowledge clock ends and shifts it out MSB first, changing SDA only while SCL is low.
- R6: After each read byte, the device samples the controller's acknowledge. On ACK it captures `rd_data_i` again and sends another byte. On NACK it releases SDA until the next START or STOP.
- R7: An address byte of 00h is acknowledged. A following data byte of 06h is acknowledged and produces a one-cycle `soft_rst_o` pulse. Any other data byte after 00h is not acknowledged and produces no pulse. General-call bytes never produce `wr_valid_o`.
- R8: A first byte matching 00001xxx is not acknowledged and sets `hs_mode_o`. The flag survives a repeated START and is cleared by STOP.
- R9: `sda_oe_o` (1 = pull SDA low) is only asserted while the filtered SCL is low. The block has no SCL output.
- R10: After reset, `sda_oe_o`, `wr_valid_o`, `soft_rst_o` and `hs_mode_o` are all low.
- R11: A pulse on SCL shorter than the majority window, one system clock long, is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| addr_sel_i | input | 1 | Strap pin supplying the address LSB |
| rd_data_i | input | 8 | Byte to send in read transfers |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| wr_data_o | output | 8 | Last received write byte |
| wr_valid_o | output | 1 | One-cycle strobe for wr_data_o |
| soft_rst_o | output | 1 | One-cycle general-call reset pulse |
| hs_mode_o | output | 1 | High-speed controller code seen since last STOP |

## Verification
The bench attacks the address decode with the select strap set both ways, so a design that ignored the strap would acknowledge the wrong address in one of the two cases. It sends a general-call byte with a code other than the reset code, which catches a design that pulses the reset on any general call or acknowledges the wrong byte. After a controller NACK it clocks another full byte, so a design that keeps transmitting would pull SDA low. It also checks that the high-speed flag survives a repeated START and is cleared only by STOP, and it injects a one-clock SCL glitch into a write byte; a design without filtering would shift an extra bit and corrupt the received byte.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [5:0]        DEV_ADDR_HI   = 6'b111010;
  localparam logic [BYTE_W-1:0] BCAST_ADDR    = 8'h00;
  localparam logic [BYTE_W-1:0] BCAST_RST     = 8'h06;
  localparam logic [4:0]        HS_CODE_TOP   = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } xfer_st_e;
endpackage

// File: rtl/cfg_i2c_filt.sv
module cfg_i2c_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VOTE_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned VCW  = $clog2(VOTE_LEN + 1);
  localparam int unsigned HALF = VOTE_LEN / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_LEN-1:0]    win_q;
  logic [VCW-1:0]         ones;
  logic                   line_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_LEN; i++) ones = ones + VCW'(win_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
      line_q <= (ones > VCW'(HALF));
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/cfg_i2c_cond.sv
module cfg_i2c_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  assign scl_rise_o = ~scl_p_q & scl_f_i;
  assign scl_fall_o = scl_p_q & ~scl_f_i;
  // SDA edge with SCL high on both samples is a bus condition
  assign start_o    = scl_p_q & scl_f_i & sda_p_q & ~sda_f_i;
  assign stop_o     = scl_p_q & scl_f_i & ~sda_p_q & sda_f_i;
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_f_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              soft_rst_o,
  output logic              hs_mode_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  xfer_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wr_data_q;
  logic              first_q, rd_q, bcast_q, ack_q, nack_q;
  logic              wr_valid_q, soft_rst_q, hs_q;
  logic [BYTE_W-1:0] byte_nxt;

  assign byte_nxt = {sh_q[BYTE_W-2:0], sda_f_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '1;
      wr_data_q  <= '0;
      first_q    <= 1'b0;
      rd_q       <= 1'b0;
      bcast_q    <= 1'b0;
      ack_q      <= 1'b0;
      nack_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      soft_rst_q <= 1'b0;
      hs_q       <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      soft_rst_q <= 1'b0;
      if (stop_i) begin
        st_q <= ST_IDLE;
        hs_q <= 1'b0;
      end else if (start_i) begin
        st_q    <= ST_RX;
        cnt_q   <= '0;
        first_q <= 1'b1;
        rd_q    <= 1'b0;
        bcast_q <= 1'b0;
        ack_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q < FULL) begin
              sh_q  <= byte_nxt;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) begin
                ack_q <= 1'b0;
                if (first_q) begin
                  if (byte_nxt[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                    ack_q <= 1'b1;
                    rd_q  <= byte_nxt[0];
                  end else if (byte_nxt == BCAST_ADDR) begin
                    ack_q   <= 1'b1;
                    bcast_q <= 1'b1;
                  end else if (byte_nxt[BYTE_W-1:3] == HS_CODE_TOP) begin
                    hs_q <= 1'b1;
                  end
                end else if (bcast_q) begin
                  if (byte_nxt == BCAST_RST) begin
                    soft_rst_q <= 1'b1;
                    ack_q      <= 1'b1;
                  end
                end else begin
                  wr_data_q  <= byte_nxt;
                  wr_valid_q <= 1'b1;
                  ack_q      <= 1'b1;
                end
              end
            end else if (scl_fall_i && cnt_q == FULL) begin
              st_q    <= ack_q ? ST_ACK : ST_SKIP;
              first_q <= 1'b0;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_q) begin
                st_q <= ST_TX;
                tx_q <= rd_data_i;
              end else begin
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST_BIT) begin
                st_q  <= ST_MACK;
                cnt_q <= '0;
                tx_q  <= '1;
              end else begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) nack_q <= sda_f_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                st_q <= ST_SKIP;
              end else begin
                st_q  <= ST_TX;
                tx_q  <= rd_data_i;
                cnt_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = (st_q == ST_ACK) | ((st_q == ST_TX) & ~tx_q[BYTE_W-1]);
  assign wr_data_o  = wr_data_q;
  assign wr_valid_o = wr_valid_q;
  assign soft_rst_o = soft_rst_q;
  assign hs_mode_o  = hs_q;
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VOTE_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              soft_rst_o,
  output logic              hs_mode_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw, clean;
  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

  assign raw   = {sda_i, scl_i};
  assign scl_f = clean[0];
  assign sda_f = clean[1];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    cfg_i2c_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_LEN   (VOTE_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(clean[g])
    );
  end

  cfg_i2c_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  cfg_i2c_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_f_i   (sda_f),
    .addr_sel_i(addr_sel_i),
    .rd_data_i (rd_data_i),
    .sda_oe_o  (sda_oe_o),
    .wr_data_o (wr_data_o),
    .wr_valid_o(wr_valid_o),
    .soft_rst_o(soft_rst_o),
    .hs_mode_o (hs_mode_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f_i,
  input logic start_i,
  input logic stop_i,
  input logic sda_oe_i,
  input logic wr_valid_i,
  input logic soft_rst_i,
  input logic hs_mode_i
);
  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_f_i);

  assert_stop_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_start_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  assert_wr_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> !wr_valid_i);

  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !soft_rst_i);

  assert_rst_not_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_i, soft_rst_i}));

  assert_stop_clears_hs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_mode_i);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f_i   (scl_f),
  .start_i   (start_det),
  .stop_i    (stop_det),
  .sda_oe_i  (sda_oe_o),
  .wr_valid_i(wr_valid_o),
  .soft_rst_i(soft_rst_o),
  .hs_mode_i (hs_mode_o)
);

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int N_VEC      = 8;

  // {addr_sel, addr byte, data byte, exp addr ack, exp data ack, exp wr pulse, exp rst pulse}
  localparam logic [20:0] VEC [N_VEC] = '{
    {1'b0, 8'hE8, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'hEA, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'hEA, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'hE8, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h20, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h00, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, wr_valid, soft_rst, hs_mode;
  logic [7:0] wr_data;
  logic sda_bus;

  int errors = 0, checks = 0, cyc = 0;
  int wr_cnt = 0, rst_cnt = 0, rst_hi = 0, r9_viol = 0;
  logic [7:0] wr_last = 8'h00;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .addr_sel_i(addr_sel),
    .rd_data_i (rd_data),
    .sda_oe_o  (sda_oe),
    .wr_data_o (wr_data),
    .wr_valid_o(wr_valid),
    .soft_rst_o(soft_rst),
    .hs_mode_o (hs_mode)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin wr_cnt++; wr_last = wr_data; end
      if (soft_rst) begin
        rst_hi++;
        if (!oe_prev || 1'b1) ;
      end
      if (soft_rst && rst_hi == 1) ;
      if (sda_oe && !oe_prev && scl_m) r9_viol++;
      oe_prev = sda_oe;
    end
  end

  // count reset pulses as rising edges of soft_rst
  logic srst_prev = 1'b0;
  always @(negedge clk) begin
    if (soft_rst && !srst_prev) rst_cnt++;
    srst_prev = soft_rst;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (i == glitch_bit) begin
        wt(Q/2); scl_m = 1'b1; wt(1); scl_m = 1'b0; wt(Q - Q/2 - 1);
      end else begin
        wt(Q);
      end
      scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = ~sda_bus;
    wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit m_ack, input logic [7:0] next_rd, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
      b[i] = sda_bus;
      wt(Q); scl_m = 1'b0; wt(Q);
    end
    rd_data = next_rd;
    sda_m = ~m_ack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    int w0, r0, h0;

    wt(5);
    // R10 reset state
    check(sda_oe == 1'b0,   "R10 sda_oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R10 wr_valid", wr_valid, 0);
    check(soft_rst == 1'b0, "R10 soft_rst", soft_rst, 0);
    check(hs_mode == 1'b0,  "R10 hs_mode", hs_mode, 0);
    rst_n = 1'b1;
    wt(10);

    for (int v = 0; v < N_VEC; v++) begin
      logic [20:0] e;
      e = VEC[v];
      addr_sel = e[20];
      w0 = wr_cnt; r0 = rst_cnt;
      wt(2);
      bus_start();
      send_byte(e[19:12], -1, ack);
      check(ack == e[3], "R1 addr ack", ack, e[3]);
      send_byte(e[11:4], -1, ack);
      check(ack == e[2], "R3 data ack", ack, e[2]);
      bus_stop();
      wt(10);
      check((wr_cnt - w0) == int'(e[1]), "R4 wr strobes", wr_cnt - w0, e[1]);
      if (e[1]) check(wr_last == e[11:4], "R3 wr data", wr_last, e[11:4]);
      check((rst_cnt - r0) == int'(e[0]), "R7 reset pulses", rst_cnt - r0, e[0]);
    end
    check(rst_hi == rst_cnt, "R7 pulse width", rst_hi, rst_cnt);

    // R4: mismatched address, SDA stays released while data is clocked
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hE2, -1, ack);
    check(ack == 1'b0, "R4 no ack", ack, 0);
    recv_byte(1'b0, 8'h00, rb);
    check(rb == 8'hFF, "R4 sda released", rb, 8'hFF);
    bus_stop();

    // R3 multi-byte write, R2 repeated start
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hE8, -1, ack);
    send_byte(8'h01, -1, ack);
    send_byte(8'h02, -1, ack);
    check(ack == 1'b1, "R3 second byte ack", ack, 1);
    bus_start();
    send_byte(8'hE8, -1, ack);
    check(ack == 1'b1, "R2 repeated start addr ack", ack, 1);
    bus_stop();
    wt(10);
    check((wr_cnt - w0) == 2, "R3 two strobes", wr_cnt - w0, 2);
    check(wr_last == 8'h02, "R3 last byte", wr_last, 8'h02);

    // R5/R6 read
    rd_data = 8'hC3;
    bus_start();
    send_byte(8'hE9, -1, ack);
    check(ack == 1'b1, "R5 read addr ack", ack, 1);
    recv_byte(1'b1, 8'h81, rb);
    check(rb == 8'hC3, "R5 first read byte", rb, 8'hC3);
    recv_byte(1'b0, 8'h00, rb);
    check(rb == 8'h81, "R6 byte after ACK", rb, 8'h81);
    recv_byte(1'b0, 8'h00, rb);
    check(rb == 8'hFF, "R6 released after NACK", rb, 8'hFF);
    bus_stop();

    // R8 high-speed code
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h0B, -1, ack);
    check(ack == 1'b0, "R8 hs code not acked", ack, 0);
    check(hs_mode == 1'b1, "R8 hs set", hs_mode, 1);
    bus_start();
    send_byte(8'hE8, -1, ack);
    send_byte(8'h44, -1, ack);
    check(hs_mode == 1'b1, "R8 hs kept over restart", hs_mode, 1);
    bus_stop();
    wt(10);
    check(hs_mode == 1'b0, "R8 hs cleared by stop", hs_mode, 0);
    check(wr_last == 8'h44, "R8 write after hs", wr_last, 8'h44);

    // R11 SCL glitch rejection
    bus_start();
    send_byte(8'hE8, -1, ack);
    send_byte(8'h96, 2, ack);
    check(ack == 1'b1, "R11 glitch byte ack", ack, 1);
    bus_stop();
    wt(10);
    check(wr_last == 8'h96, "R11 glitch byte data", wr_last, 8'h96);

    check(r9_viol == 0, "R9 drive only with SCL low", r9_viol, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule